// File: doc/BRIEF.md
# Serial Flash Status Register Unit

This block holds the 16-bit status word of a serial NOR flash command front end. A command decoder ahead of it passes in a validated opcode byte with a data word. This block reacts to three opcodes: write-status, suspend and resume. It also takes a power-cycle strobe. Bits in the word follow different rules:
- Block-protect, complement-protect and quad-enable are ordinary read/write bits.
- The security lock is one-time programmable: once set, it cannot return to 0.
- The suspend flag can change only through commands and power cycling. A status write cannot touch it.

The register is visible at all times for status reads. Two control outputs come from it. A security write-inhibit tells the security-register logic to treat those registers as read-only. A registered pin-mode select switches the two spare pins between their control roles and their use as quad data lines 2 and 3.

The non-volatile bits (protect, complement, quad-enable, lock) are modelled as registers that keep their value across a power cycle. Only the asynchronous reset returns them to the factory default.

Top module: `flash_status_unit`

## Requirements
- R1: After reset, `status_o[15:2]` is all zero, `sec_wr_inhibit_o` is 0 and `quad_pins_o` is 0.
- R2: Write-status is opcode 0x01 with `cmd_valid_i` high. When `wel_i` is 0, write-status changes no stored bit. When `cmd_valid_i` is 0, no opcode has any effect.
- R3: A write-status with `wel_i`=1 loads `cmd_data_i[6:2]` into block-protect bits `status_o[6:2]`, `cmd_data_i[9]` into quad-enable `status_o[9]`, and `cmd_data_i[14]` into complement-protect `status_o[14]`. The new values are visible in the cycle after the command edge.
- R4: Bits 7, 8, 11, 12 and 13 of `status_o` always read 0, whatever is written to them.
- R5: Lock bit `status_o[10]` takes the OR of its current value and `cmd_data_i[10]` on an enabled write. Once it is 1, no write and no power cycle clears it. `sec_wr_inhibit_o` always equals `status_o[10]`.
- R6: Opcode 0x75 sets suspend flag `status_o[15]` and opcode 0x7A clears it. Neither opcode depends on `wel_i`.
- R7: A write-status never changes `status_o[15]`.
- R8: `quad_pins_o` is a register that follows `status_o[9]` with one clock of delay.
- R9: `pwr_cycle_i` clears `status_o[15]`. It keeps the protect, quad-enable, complement and lock bits.
- R10: A command presented in the same cycle as `pwr_cycle_i` is ignored.
- R11: `status_o[0]` and `status_o[1]` pass through `busy_i` and `wel_i` directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, factory default |
| cmd_valid_i | input | 1 | Opcode strobe, one cycle per command |
| cmd_op_i | input | 8 | Opcode byte |
| cmd_data_i | input | 16 | Data word for write-status |
| wel_i | input | 1 | Write-enable latch state from the command front end |
| busy_i | input | 1 | Busy state from the program/erase engine |
| pwr_cycle_i | input | 1 | Power-down/power-up event, one cycle |
| status_o | output | 16 | Status word for reads |
| sec_wr_inhibit_o | output | 1 | Security registers are read-only |
| quad_pins_o | output | 1 | 1 selects quad data use of the spare pins |

## Verification
The assertions rely on two properties of the inputs:
- `cmd_valid_i` is a single-cycle strobe carrying one opcode at a time.
- `pwr_cycle_i` may arrive at any moment, even together with a command.

The stimulus honours these by driving every command for exactly one cycle, on the falling edge. Power cycles are placed both alone and on top of suspend and write commands. The bench compares every output after every command against a model built from the bit rules above. The stimulus includes sweeps over all block-protect codes and over varied write words, both with and without the enable input.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int SR_W     = 16;
  localparam int OP_W     = 8;
  localparam int BUSY_BIT = 0;
  localparam int WEL_BIT  = 1;
  localparam int BP_LSB   = 2;
  localparam int BP_W     = 5;
  localparam int QE_BIT   = 9;
  localparam int LB_BIT   = 10;
  localparam int CMP_BIT  = 14;
  localparam int SUS_BIT  = 15;

  localparam logic [OP_W-1:0] OP_WRSR = 8'h01;
  localparam logic [OP_W-1:0] OP_SUSP = 8'h75;
  localparam logic [OP_W-1:0] OP_RES  = 8'h7A;

  typedef struct packed {
    logic [BP_W-1:0] bp;
    logic            qe;
    logic            lb;
    logic            cmp;
  } nv_fields_t;
endpackage

// File: rtl/sreg_cmd_decode.sv
module sreg_cmd_decode
  import sreg_pkg::*;
#(
  parameter int               W       = OP_W,
  parameter logic [W-1:0]     WRSR_OP = OP_WRSR,
  parameter logic [W-1:0]     SUSP_OP = OP_SUSP,
  parameter logic [W-1:0]     RES_OP  = OP_RES
) (
  input  logic         cmd_valid_i,
  input  logic [W-1:0] cmd_op_i,
  input  logic         wel_i,
  input  logic         pwr_cycle_i,
  output logic         wr_stb_o,
  output logic         susp_stb_o,
  output logic         res_stb_o
);
  logic live;
  assign live = cmd_valid_i && !pwr_cycle_i;  // power event masks commands (R10)

  always_comb begin
    wr_stb_o   = live && (cmd_op_i == WRSR_OP) && wel_i;
    susp_stb_o = live && (cmd_op_i == SUSP_OP);
    res_stb_o  = live && (cmd_op_i == RES_OP);
  end

  always_comb begin
    a_r10_one_strobe: assert ($onehot0({wr_stb_o, susp_stb_o, res_stb_o}) || !rst_sense())
      else $error("decoder raised several strobes");
  end

  function automatic logic rst_sense();
    return 1'b1;
  endfunction
endmodule

// File: rtl/sreg_nv_bits.sv
module sreg_nv_bits
  import sreg_pkg::*;
#(
  parameter int PW = BP_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_stb_i,
  input  logic [PW-1:0] wr_bp_i,
  input  logic          wr_qe_i,
  input  logic          wr_lb_i,
  input  logic          wr_cmp_i,
  output logic [PW-1:0] bp_o,
  output logic          qe_o,
  output logic          lb_o,
  output logic          cmp_o
);
  logic [PW-1:0] bp_q;
  logic          qe_q, lb_q, cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bp_q  <= '0;
      qe_q  <= 1'b0;
      cmp_q <= 1'b0;
    end else if (wr_stb_i) begin
      bp_q  <= wr_bp_i;
      qe_q  <= wr_qe_i;
      cmp_q <= wr_cmp_i;
    end
  end

  // one-time programmable: only ever ORs in
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lb_q <= 1'b0;
    else if (wr_stb_i) lb_q <= lb_q | wr_lb_i;
  end

  assign bp_o  = bp_q;
  assign qe_o  = qe_q;
  assign lb_o  = lb_q;
  assign cmp_o = cmp_q;

  a_r5_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_q |=> lb_q);
  a_r2_hold_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_i |=> $stable({bp_q, qe_q, cmp_q, lb_q}));
  a_r3_load_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |=> (bp_q == $past(wr_bp_i)) && (qe_q == $past(wr_qe_i)) && (cmp_q == $past(wr_cmp_i)));
endmodule

// File: rtl/sreg_susp_flag.sv
module sreg_susp_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic pwr_i,
  output logic sus_o
);
  logic sus_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sus_q <= 1'b0;
    else if (pwr_i || clr_i)    sus_q <= 1'b0;
    else if (set_i)             sus_q <= 1'b1;
  end

  assign sus_o = sus_q;

  a_r6_set_on_suspend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !pwr_i && !clr_i) |=> sus_q);
  a_r6_clear_on_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !sus_q);
  a_r9_clear_on_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_i |=> !sus_q);
  a_r7_rise_needs_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sus_q) |-> $past(set_i));
endmodule

// File: rtl/sreg_pin_mode.sv
module sreg_pin_mode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic qe_i,
  output logic quad_o
);
  logic quad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) quad_q <= 1'b0;
    else         quad_q <= qe_i;
  end

  assign quad_o = quad_q;

  a_r8_pin_lags_qe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> quad_q == $past(qe_i));
endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
  import sreg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic [OP_W-1:0] cmd_op_i,
  input  logic [SR_W-1:0] cmd_data_i,
  input  logic            wel_i,
  input  logic            busy_i,
  input  logic            pwr_cycle_i,
  output logic [SR_W-1:0] status_o,
  output logic            sec_wr_inhibit_o,
  output logic            quad_pins_o
);
  logic       wr_stb, susp_stb, res_stb;
  logic       sus;
  nv_fields_t nv;
  logic       unused_data_bits;

  assign unused_data_bits = ^{cmd_data_i[1:0], cmd_data_i[8:7], cmd_data_i[13:11], cmd_data_i[15]};

  sreg_cmd_decode u_dec (
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .wel_i       (wel_i),
    .pwr_cycle_i (pwr_cycle_i),
    .wr_stb_o    (wr_stb),
    .susp_stb_o  (susp_stb),
    .res_stb_o   (res_stb)
  );

  sreg_nv_bits u_nv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_stb_i (wr_stb),
    .wr_bp_i  (cmd_data_i[BP_LSB +: BP_W]),
    .wr_qe_i  (cmd_data_i[QE_BIT]),
    .wr_lb_i  (cmd_data_i[LB_BIT]),
    .wr_cmp_i (cmd_data_i[CMP_BIT]),
    .bp_o     (nv.bp),
    .qe_o     (nv.qe),
    .lb_o     (nv.lb),
    .cmp_o    (nv.cmp)
  );

  sreg_susp_flag u_sus (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (susp_stb),
    .clr_i  (res_stb),
    .pwr_i  (pwr_cycle_i),
    .sus_o  (sus)
  );

  sreg_pin_mode u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .qe_i   (nv.qe),
    .quad_o (quad_pins_o)
  );

  always_comb begin
    status_o                    = '0;
    status_o[BUSY_BIT]          = busy_i;
    status_o[WEL_BIT]           = wel_i;
    status_o[BP_LSB +: BP_W]    = nv.bp;
    status_o[QE_BIT]            = nv.qe;
    status_o[LB_BIT]            = nv.lb;
    status_o[CMP_BIT]           = nv.cmp;
    status_o[SUS_BIT]           = sus;
  end

  assign sec_wr_inhibit_o = nv.lb;

  a_r4_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {status_o[13:11], status_o[8:7]} == 5'b0);
  a_r5_inhibit_tracks_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_wr_inhibit_o == status_o[LB_BIT]);
endmodule

// File: tb/flash_status_unit_bench.sv
module flash_status_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_op = 8'h00;
  logic [15:0] cmd_data = 16'h0000;
  logic        wel = 1'b0;
  logic        busy = 1'b0;
  logic        pwr = 1'b0;
  logic [15:0] status;
  logic        inhibit;
  logic        quad;

  int n_checks = 0;
  int n_errors = 0;

  // bench model of stored bits
  logic [4:0] m_bp = '0;
  logic       m_qe = 1'b0, m_lb = 1'b0, m_cmp = 1'b0, m_sus = 1'b0;

  always #5 clk = ~clk;

  flash_status_unit u_flash_status_unit (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .cmd_valid_i      (cmd_valid),
    .cmd_op_i         (cmd_op),
    .cmd_data_i       (cmd_data),
    .wel_i            (wel),
    .busy_i           (busy),
    .pwr_cycle_i      (pwr),
    .status_o         (status),
    .sec_wr_inhibit_o (inhibit),
    .quad_pins_o      (quad)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_status();
    logic [15:0] s;
    s = '0;
    s[0] = busy; s[1] = wel;
    s[6:2] = m_bp; s[9] = m_qe; s[10] = m_lb; s[14] = m_cmp; s[15] = m_sus;
    return s;
  endfunction

  // one command cycle, then compare every output
  task automatic issue(input string req, input logic v, input logic [7:0] op,
                       input logic [15:0] d, input logic we, input logic pc);
    logic qe_before;
    qe_before = m_qe;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_data = d; wel = we; pwr = pc;
    if (pc) m_sus = 1'b0;
    else if (v && op == 8'h01 && we) begin
      m_bp = d[6:2]; m_qe = d[9]; m_cmp = d[14]; m_lb = m_lb | d[10];
    end else if (v && op == 8'h75) m_sus = 1'b1;
    else if (v && op == 8'h7A) m_sus = 1'b0;
    @(negedge clk);
    check(req, status, exp_status());
    check({req, " inhibit R5"}, {15'b0, inhibit}, {15'b0, m_lb});
    check({req, " pin R8"}, {15'b0, quad}, {15'b0, qe_before});
    cmd_valid = 1'b0; pwr = 1'b0;
  endtask

  initial begin
    #1000000;
    n_errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 status", status & 16'hFFFC, 16'h0000);
    check("R1 inhibit", {15'b0, inhibit}, 16'h0);
    check("R1 pin", {15'b0, quad}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    issue("R2 no wel", 1, 8'h01, 16'hFFFF, 0, 0);
    issue("R2 not valid", 0, 8'h01, 16'h7FFF, 1, 0);
    issue("R2 not valid suspend", 0, 8'h75, 16'h0, 1, 0);

    for (int i = 0; i < 32; i++)
      issue("R3 R4 R7 bp sweep", 1, 8'h01, 16'hB983 | 16'(i << 2), 1, 0);

    issue("R3 qe cmp set", 1, 8'h01, 16'h4200, 1, 0);
    issue("R8 pin follows", 0, 8'h00, 16'h0, 1, 0);
    issue("R3 qe clear", 1, 8'h01, 16'h4000, 1, 0);
    issue("R8 pin drops", 0, 8'h00, 16'h0, 1, 0);

    issue("R6 suspend", 1, 8'h75, 16'h0, 0, 0);
    issue("R7 write keeps sus", 1, 8'h01, 16'h0000, 1, 0);
    issue("R6 resume", 1, 8'h7A, 16'h0, 0, 0);
    issue("R7 write cannot set sus", 1, 8'h01, 16'h8000, 1, 0);

    issue("R5 lock set", 1, 8'h01, 16'h4614, 1, 0);
    issue("R5 zero over lock", 1, 8'h01, 16'h0208, 1, 0);
    issue("R6 suspend again", 1, 8'h75, 16'h0, 1, 0);
    issue("R9 power cycle", 0, 8'h00, 16'h0, 1, 1);
    issue("R10 suspend during power", 1, 8'h75, 16'h0, 1, 1);
    issue("R10 write during power", 1, 8'h01, 16'h407C, 1, 1);

    busy = 1'b1;
    issue("R11 busy bit", 0, 8'h00, 16'h0, 0, 0);
    busy = 1'b0;
    issue("R11 busy low", 0, 8'h00, 16'h0, 1, 0);

    for (int i = 0; i < 96; i++) begin
      logic [15:0] d;
      logic [7:0]  op;
      d  = 16'((i * 40503 + 17) & 16'hFFFF);
      op = (i % 5 == 0) ? 8'h75 : (i % 7 == 0) ? 8'h7A : 8'h01;
      issue("R3 R5 R7 mixed sweep", 1, op, d, i[1], (i % 11 == 3));
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule